// File: doc/BRIEF.md
# RTC Register File with Byte-Serial Access

This block is the byte-wide register front end of a real-time-clock peripheral. It sits behind a serial-bus slave transaction layer that has already decoded the bus into single-cycle strobes: write start, read start, stop, one written byte, and a request for one read byte. The block holds 32 byte registers that are reached through a 5-bit auto-incrementing pointer. It applies per-field write masks and the protection rules for the status and configuration registers. It also raises a soft-reset pulse when software asks for one.

The live time comes from an external counter chain as seven BCD bytes. Whenever a read transaction begins, and again whenever the pointer rolls over during a burst, these bytes are frozen into the readable time registers. The host therefore always sees a coherent snapshot. The upper half of the map duplicates the time registers and the three configuration and status registers. A write to either copy of a configuration or status register keeps both copies equal.

Top module: `rtc_regfile`

## Requirements
- R1: Every data byte written and every byte read advances the 5-bit pointer by one, and the pointer wraps from 0x1F to 0x00.
- R2: The first byte after a write start loads the pointer from its low 5 bits and changes no register. The next written byte lands at that address.
- R3: A read start copies the live seconds, minutes, hours, weekday, day, month and year into locations 0x00–0x06 and into their copies at 0x10–0x16.
- R4: When an access at pointer 0x1F wraps the pointer to 0x00, the live time is captured again in the same way as R3.
- R5: Writes to a time register (low address nibble 0–6) are masked as follows: seconds and minutes keep bits 6:0, hours and day keep bits 5:0, month keeps bits 4:0, and weekday and year are stored unchanged.
- R6: A write to a weekday location (low nibble 3) whose value is not one of 0x01, 0x02, 0x04, 0x08, 0x10, 0x20 or 0x40 pulses `wday_err` high for one cycle, one clock after the byte.
- R7: The control register (0x0F/0x1F) has write-protect bits at positions 1 and 2. A write cannot change either bit from 0 to 1.
- R8: Writing control bit 0 as 1 pulses `soft_reset_req` for one cycle. It also restores the extension register to 0x02, the flag register to 0x03 and the temperature register (0x17) to 135, and stores the rest of the written control value with bit 0 cleared.
- R9: In the flag register (0x0E/0x1E), bits 0, 1, 2, 6 and 7 can be written to 0 but cannot be set from 0 to 1 by a write. Bits 3 to 5 are stored as written.
- R10: The extension (0x0D/0x1D), flag and control registers are kept as pairs. A write to either address updates both copies.
- R11: After reset the extension register reads 0x02, the flag register 0x03, the control register 0x40, the temperature register 135, all other locations 0, and `rd_data` is 0.
- R12: A read request returns the byte at the pointer on `rd_data` one clock later. `rd_data` holds that byte until the next read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start | input | 1 | Start of a write transaction; the next byte is the address |
| rd_start | input | 1 | Start of a read transaction; triggers the time snapshot |
| stop | input | 1 | End of a transaction |
| wr_valid | input | 1 | One written byte is on `wr_data` |
| wr_data | input | 8 | Written byte |
| rd_req | input | 1 | Request for one read byte |
| now_sec | input | 8 | Live seconds, BCD |
| now_min | input | 8 | Live minutes, BCD |
| now_hour | input | 8 | Live hours, BCD |
| now_wday | input | 8 | Live weekday, one-hot |
| now_day | input | 8 | Live day of month, BCD |
| now_mon | input | 8 | Live month, BCD |
| now_year | input | 8 | Live year, two BCD digits |
| rd_data | output | 8 | Byte returned by the last read request |
| soft_reset_req | output | 1 | One-cycle soft-reset pulse |
| wday_err | output | 1 | One-cycle pulse for an illegal weekday write |

## Verification
The assertions assume that the transaction layer raises at most one of the five strobes in any cycle. The snapshot and pointer properties depend on this: a capture never coincides with a write to a time location. The bench drives each strobe in its own cycle and returns all of them to zero between steps. Writes to the pointer-wrap location and reads through the wrap are exercised with the live time changing between steps, so that the second capture can be told apart from the first.

// File: rtl/rtc_regfile_pkg.sv
package rtc_regfile_pkg;
   localparam int BYTE_W   = 8;
   localparam int PTR_W    = 5;
   localparam int TIME_CNT = 7;

   // low-nibble decode of the map (upper half mirrors the lower)
   localparam logic [3:0] LO_SEC   = 4'h0;
   localparam logic [3:0] LO_MIN   = 4'h1;
   localparam logic [3:0] LO_HOUR  = 4'h2;
   localparam logic [3:0] LO_WDAY  = 4'h3;
   localparam logic [3:0] LO_DAY   = 4'h4;
   localparam logic [3:0] LO_MON   = 4'h5;
   localparam logic [3:0] LO_YEAR  = 4'h6;
   localparam logic [3:0] LO_EXTN  = 4'hD;
   localparam logic [3:0] LO_STAT  = 4'hE;
   localparam logic [3:0] LO_CONF  = 4'hF;

   localparam int IDX_EXTN = 13;
   localparam int IDX_STAT = 14;
   localparam int IDX_CONF = 15;
   localparam int IDX_TEMP = 23;

   localparam logic [7:0] MASK_SM    = 8'h7F;
   localparam logic [7:0] MASK_HD    = 8'h3F;
   localparam logic [7:0] MASK_MON   = 8'h1F;
   localparam logic [7:0] STAT_LOCK  = 8'hC7;  // set-protected flag bits
   localparam logic [7:0] CONF_WPROT = 8'h06;  // write-protect bits
   localparam int         CONF_SRST  = 0;      // self-clearing reset bit

   localparam logic [7:0] INIT_EXTN = 8'h02;
   localparam logic [7:0] INIT_STAT = 8'h03;
   localparam logic [7:0] INIT_CONF = 8'h40;
   localparam logic [7:0] INIT_TEMP = 8'd135;

   function automatic logic [7:0] init_value(int idx);
      case (idx % 16)
         IDX_EXTN: return INIT_EXTN;
         IDX_STAT: return INIT_STAT;
         IDX_CONF: return INIT_CONF;
         default:  return (idx == IDX_TEMP) ? INIT_TEMP : 8'h00;
      endcase
   endfunction

   function automatic bit soft_target(int idx);
      return ((idx % 16) >= IDX_EXTN) || (idx == IDX_TEMP);
   endfunction
endpackage

// File: rtl/rtc_ptr_ctrl.sv
module rtc_ptr_ctrl #(
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_start,
   input  logic              rd_start,
   input  logic              stop,
   input  logic              wr_valid,
   input  logic              rd_req,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] ptr,
   output logic              addr_byte,
   output logic              data_wr,
   output logic              wrap_cap
);
   logic addr_phase;
   logic step;

   generate
      if (ADDR_W < 1) begin : g_bad_width
         $error("rtc_ptr_ctrl: ADDR_W must be positive");
      end
   endgenerate

   assign addr_byte = wr_valid && addr_phase;
   assign data_wr   = wr_valid && !addr_phase;
   assign step      = data_wr || rd_req;
   assign wrap_cap  = step && (ptr == {ADDR_W{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr        <= '0;
         addr_phase <= 1'b0;
      end else begin
         if (wr_start)
            addr_phase <= 1'b1;
         else if (stop)
            addr_phase <= 1'b0;
         if (addr_byte) begin
            ptr        <= addr_in;
            addr_phase <= 1'b0;
         end else if (step) begin
            ptr <= ptr + ADDR_W'(1);
         end
      end
   end

   // input assumption: one strobe per cycle
   p_strobe_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({wr_start, rd_start, stop, wr_valid, rd_req}) <= 1);

   p_ptr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> ptr == ADDR_W'($past(ptr) + ADDR_W'(1)));

   p_addr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      addr_byte |=> ptr == $past(addr_in));
endmodule

// File: rtl/rtc_wr_filter.sv
module rtc_wr_filter
   import rtc_regfile_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 5
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] cur,
   output logic [DATA_W-1:0] nxt,
   output logic              srst_req,
   output logic              wday_bad
);
   logic [3:0] low;

   generate
      if (DATA_W != BYTE_W) begin : g_bad_data
         $error("rtc_wr_filter: field masks assume byte registers");
      end
   endgenerate

   assign low = addr[3:0];

   always_comb begin
      nxt      = wdata;
      srst_req = 1'b0;
      wday_bad = 1'b0;
      case (low)
         LO_SEC, LO_MIN:  nxt = wdata & MASK_SM;
         LO_HOUR, LO_DAY: nxt = wdata & MASK_HD;
         LO_MON:          nxt = wdata & MASK_MON;
         LO_WDAY:         wday_bad = wdata[7] || !$onehot(wdata[6:0]);
         LO_STAT:         nxt = wdata & ~(~cur & STAT_LOCK);
         LO_CONF: begin
            nxt            = wdata & ~(~cur & CONF_WPROT);
            srst_req       = wdata[CONF_SRST];
            nxt[CONF_SRST] = 1'b0;
         end
         default:         nxt = wdata;
      endcase
   end
endmodule

// File: rtl/rtc_reg_bank.sv
module rtc_reg_bank
   import rtc_regfile_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 5,
   parameter int N_TIME = 7
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_val,
   input  logic                       cap_en,
   input  logic [N_TIME*DATA_W-1:0]   cap_time,
   input  logic                       soft_rst,
   input  logic [ADDR_W-1:0]          rd_addr,
   output logic [DATA_W-1:0]          rd_val
);
   localparam int NREG = 1 << ADDR_W;
   localparam int HALF = NREG / 2;

   logic [DATA_W-1:0] q [NREG];

   generate
      if (ADDR_W != PTR_W) begin : g_bad_addr
         $error("rtc_reg_bank: map layout needs a 5-bit pointer");
      end
      if (N_TIME > 16) begin : g_bad_time
         $error("rtc_reg_bank: too many time fields");
      end
      for (genvar i = 0; i < NREG; i++) begin : g_cell
         localparam logic [ADDR_W-1:0] MY_A   = ADDR_W'(i);
         localparam logic [ADDR_W-1:0] TWIN_A = ADDR_W'(i ^ HALF);
         localparam bit IS_PAIR = (i % 16) >= IDX_EXTN;
         localparam bit IS_TIME = (i % 16) < N_TIME;
         localparam bit IS_SOFT = soft_target(i);
         localparam logic [DATA_W-1:0] RV = DATA_W'(init_value(i));
         logic hit;

         assign hit = wr_en && ((wr_addr == MY_A) || (IS_PAIR && (wr_addr == TWIN_A)));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q[i] <= RV;
            else if (hit)
               q[i] <= wr_val;
            else if (cap_en && IS_TIME)
               q[i] <= cap_time[(i % 16)*DATA_W +: DATA_W];
            else if (soft_rst && IS_SOFT)
               q[i] <= RV;
         end
      end
   endgenerate

   assign rd_val = q[rd_addr];

   p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cap_en) |-> (q[0] == $past(cap_time[DATA_W-1:0]))
                     && (q[HALF] == $past(cap_time[DATA_W-1:0])));

   p_wprot_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (q[IDX_CONF][2:1] == 2'b00) && (q[IDX_CONF+HALF][2:1] == 2'b00));

   p_srst_bit_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !q[IDX_CONF][CONF_SRST] && !q[IDX_CONF+HALF][CONF_SRST]);

   p_stat_clear_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(soft_rst) && !$past(q[IDX_STAT][1])) |-> !q[IDX_STAT][1]);

   p_pair_equal_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (q[IDX_EXTN] == q[IDX_EXTN+HALF]) && (q[IDX_STAT] == q[IDX_STAT+HALF])
      && (q[IDX_CONF] == q[IDX_CONF+HALF]));
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
   import rtc_regfile_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_start,
   input  logic              rd_start,
   input  logic              stop,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_req,
   input  logic [DATA_W-1:0] now_sec,
   input  logic [DATA_W-1:0] now_min,
   input  logic [DATA_W-1:0] now_hour,
   input  logic [DATA_W-1:0] now_wday,
   input  logic [DATA_W-1:0] now_day,
   input  logic [DATA_W-1:0] now_mon,
   input  logic [DATA_W-1:0] now_year,
   output logic [DATA_W-1:0] rd_data,
   output logic              soft_reset_req,
   output logic              wday_err
);
   localparam int TIME_BITS = TIME_CNT * DATA_W;

   logic [ADDR_W-1:0]    ptr;
   logic                 addr_byte, data_wr, wrap_cap, cap_en;
   logic [DATA_W-1:0]    cur_val, new_val;
   logic                 srst_req, wday_bad, srst_now;
   logic [TIME_BITS-1:0] live_time;

   generate
      if (DATA_W != BYTE_W) begin : g_bad_data
         $error("rtc_regfile: DATA_W must be 8");
      end
   endgenerate

   assign live_time = {now_year, now_mon, now_day, now_wday, now_hour, now_min, now_sec};
   assign cap_en    = rd_start || wrap_cap;
   assign srst_now  = data_wr && srst_req;

   rtc_ptr_ctrl #(.ADDR_W(ADDR_W)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .wr_start(wr_start), .rd_start(rd_start), .stop(stop),
      .wr_valid(wr_valid), .rd_req(rd_req),
      .addr_in(wr_data[ADDR_W-1:0]),
      .ptr(ptr), .addr_byte(addr_byte), .data_wr(data_wr), .wrap_cap(wrap_cap)
   );

   rtc_wr_filter #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_filt (
      .addr(ptr), .wdata(wr_data), .cur(cur_val),
      .nxt(new_val), .srst_req(srst_req), .wday_bad(wday_bad)
   );

   rtc_reg_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_TIME(TIME_CNT)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(data_wr), .wr_addr(ptr), .wr_val(new_val),
      .cap_en(cap_en), .cap_time(live_time),
      .soft_rst(srst_now),
      .rd_addr(ptr), .rd_val(cur_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data        <= '0;
         soft_reset_req <= 1'b0;
         wday_err       <= 1'b0;
      end else begin
         if (rd_req)
            rd_data <= cur_val;
         soft_reset_req <= srst_now;
         wday_err       <= data_wr && wday_bad;
      end
   end

   p_wday_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wday_err |-> $past(wr_valid) && ($past(ptr[3:0]) == LO_WDAY));

   p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rd_req) |-> $stable(rd_data));
endmodule

// File: tb/test_rtc_regfile.sv
`timescale 1ns/1ps
module test_rtc_regfile;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_start = 0, rd_start = 0, stop = 0, wr_valid = 0, rd_req = 0;
   logic [7:0] wr_data = 0;
   logic [7:0] lt [7];
   logic [7:0] rd_data;
   logic soft_reset_req, wday_err;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   // reference model state
   logic [7:0] m_mem [32];
   int   m_ptr = 0;
   bit   m_aph = 0;
   logic [7:0] e_rd = 0;
   bit   e_srst = 0, e_werr = 0;

   always #2.5 clk = ~clk;

   rtc_regfile i_rtc_regfile (
      .clk(clk), .rst_n(rst_n),
      .wr_start(wr_start), .rd_start(rd_start), .stop(stop),
      .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
      .now_sec(lt[0]), .now_min(lt[1]), .now_hour(lt[2]), .now_wday(lt[3]),
      .now_day(lt[4]), .now_mon(lt[5]), .now_year(lt[6]),
      .rd_data(rd_data), .soft_reset_req(soft_reset_req), .wday_err(wday_err)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic m_capture();
      for (int k = 0; k < 7; k++) begin
         m_mem[k]      = lt[k];
         m_mem[16 + k] = lt[k];
      end
   endtask

   task automatic m_advance();
      m_ptr = (m_ptr + 1) % 32;
      if (m_ptr == 0) m_capture();
   endtask

   task automatic m_write(input logic [7:0] d);
      logic [7:0] v;
      int lo;
      lo = m_ptr % 16;
      v  = d;
      case (lo)
         0, 1: v = d & 8'h7F;
         2, 4: v = d & 8'h3F;
         5:    v = d & 8'h1F;
         3:    e_werr = !(d inside {8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40});
         14:   v = d & ~(~m_mem[m_ptr] & 8'hC7);
         15: begin
            v = d & ~(~m_mem[m_ptr] & 8'h06);
            if (d[0]) begin
               e_srst = 1;
               m_mem[13] = 8'h02; m_mem[29] = 8'h02;
               m_mem[14] = 8'h03; m_mem[30] = 8'h03;
               m_mem[23] = 8'd135;
            end
            v[0] = 1'b0;
         end
         default: v = d;
      endcase
      m_mem[m_ptr] = v;
      if (lo >= 13) m_mem[m_ptr ^ 16] = v;
   endtask

   task automatic step(input bit ws, input bit rs, input bit sp, input bit wv,
                       input bit rr, input logic [7:0] wd, input string tag);
      wr_start = ws; rd_start = rs; stop = sp; wr_valid = wv; rd_req = rr; wr_data = wd;
      e_srst = 0; e_werr = 0;
      if (ws) m_aph = 1;
      else if (sp) m_aph = 0;
      if (wv && m_aph) begin
         m_ptr = int'(wd[4:0]);
         m_aph = 0;
      end else if (wv) begin
         m_write(wd);
         m_advance();
      end else if (rr) begin
         e_rd = m_mem[m_ptr];
         m_advance();
      end
      if (rs) m_capture();
      @(negedge clk);
      wr_start = 0; rd_start = 0; stop = 0; wr_valid = 0; rd_req = 0;
      chk(tag, rd_data, e_rd);
      chk("R8 soft_reset_req", {7'd0, soft_reset_req}, {7'd0, e_srst});
      chk("R6 wday_err", {7'd0, wday_err}, {7'd0, e_werr});
   endtask

   task automatic set_ptr(input logic [7:0] a, input string tag);
      step(1, 0, 0, 0, 0, 0, tag);
      step(0, 0, 0, 1, 0, a, tag);
   endtask
   task automatic wb(input logic [7:0] d, input string tag);
      step(0, 0, 0, 1, 0, d, tag);
   endtask
   task automatic rb(input string tag);
      step(0, 0, 0, 0, 1, 0, tag);
   endtask
   task automatic idle(input string tag);
      step(0, 0, 0, 0, 0, 0, tag);
   endtask
   task automatic set_time(input logic [7:0] b);
      lt[0] = 8'h59 ^ b; lt[1] = 8'h34 ^ b; lt[2] = 8'h12 ^ b; lt[3] = 8'h08;
      lt[4] = 8'h28 ^ b; lt[5] = 8'h11 ^ b; lt[6] = 8'h16 ^ b;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      set_time(8'h00);
      for (int k = 0; k < 32; k++) m_mem[k] = 8'h00;
      m_mem[13] = 8'h02; m_mem[29] = 8'h02;
      m_mem[14] = 8'h03; m_mem[30] = 8'h03;
      m_mem[15] = 8'h40; m_mem[31] = 8'h40;
      m_mem[23] = 8'd135;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 rd_data after reset", rd_data, 8'h00);
      chk("R11 soft_reset_req idle", {7'd0, soft_reset_req}, 8'h00);
      set_ptr(8'h0D, "R2 pointer load");
      rb("R11 extension reset"); rb("R11 flag reset"); rb("R11 control reset");
      rb("R11 mirror 0x10 zero");
      set_ptr(8'h17, "R2");
      rb("R11 temperature reset");
      idle("R12 hold"); idle("R12 hold");

      // R3 snapshot on read start
      set_ptr(8'h00, "R2");
      step(0, 1, 0, 0, 0, 0, "R3 read start");
      set_time(8'h01);
      for (int k = 0; k < 7; k++) rb("R3 primary snapshot");
      set_ptr(8'h10, "R2");
      for (int k = 0; k < 7; k++) rb("R3 mirror snapshot");
      step(0, 0, 1, 0, 0, 0, "R1 stop");

      // R5 masks, R1 increment
      set_ptr(8'h00, "R2");
      wb(8'hFF, "R5"); wb(8'hFF, "R5"); wb(8'hFF, "R5"); wb(8'h08, "R6 legal weekday");
      wb(8'hFF, "R5"); wb(8'hFF, "R5"); wb(8'h99, "R5"); wb(8'hA5, "R1 plain byte");
      set_ptr(8'h00, "R2");
      for (int k = 0; k < 8; k++) rb("R5 masked time readback");

      // R6 illegal weekday values
      set_ptr(8'h03, "R2"); wb(8'h03, "R6 two bits");
      set_ptr(8'h13, "R2"); wb(8'h80, "R6 bit 7");
      set_ptr(8'h03, "R2"); wb(8'h40, "R6 legal top");

      // R7 write protect, R10 mirror
      set_ptr(8'h0F, "R2"); wb(8'h0E, "R7 protect");
      set_ptr(8'h0F, "R2"); rb("R7 control readback");
      set_ptr(8'h1F, "R2"); rb("R10 control mirror");

      // R9 flag protection
      set_ptr(8'h0E, "R2"); wb(8'h00, "R9 clear");
      set_ptr(8'h1E, "R2"); wb(8'hFF, "R9 set attempt");
      set_ptr(8'h0E, "R2"); rb("R9 flag readback");

      // R10 write via mirror address
      set_ptr(8'h1D, "R2"); wb(8'h5A, "R10 extension via mirror");
      set_ptr(8'h0D, "R2"); rb("R10 extension primary");
      set_ptr(8'h17, "R2"); wb(8'h21, "R1 temperature write");

      // R8 soft reset
      set_ptr(8'h0F, "R2"); wb(8'h89, "R8 reset bit");
      idle("R8 pulse ends");
      set_ptr(8'h0D, "R2");
      rb("R8 extension restored"); rb("R8 flag restored"); rb("R8 control stored");
      set_ptr(8'h17, "R2"); rb("R8 temperature restored");
      set_ptr(8'h1D, "R2"); rb("R8 mirror restored");

      // R4 wrap capture on read and on write
      set_time(8'h02);
      set_ptr(8'h1E, "R2");
      rb("R1 read 0x1E"); rb("R4 read 0x1F wraps");
      set_time(8'h03);
      rb("R4 second capture"); rb("R4 minutes");
      set_ptr(8'h1F, "R2"); wb(8'h40, "R4 write wraps");
      set_time(8'h04);
      wb(8'h45, "R4 write after wrap");
      set_ptr(8'h10, "R2"); rb("R4 mirror after write wrap"); rb("R4 mirror min");
      set_ptr(8'h00, "R2"); rb("R4 seconds overwritten"); rb("R4 minutes");
      idle("R12 final hold");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule